// File: doc/BRIEF.md
# Three-Phase PWM Timer with Gated Compare Reload

This block is a 12-bit PWM time base for a three-phase motor bridge. It has four compare channels: a reference compare that sets the top of the count, and one compare for each of the phases U, V and W. Software writes each compare through a preload register. A preload reaches its active compare only on an update event. An update event happens when the counter wraps and an auto-reloading 8-bit repetition counter has reached zero. This lets software set how often the duty cycles may change.

The counter runs in one of two modes. In edge mode it counts up to the reference value and restarts from zero. In center mode it counts up to the reference value and then back down to zero. In center mode both turning points count as wrap events, so the duty cycle can be refreshed twice in every PWM period. Each update event raises a one-cycle debug pulse. It also sets an interrupt flag, which stays set until software clears it.

The counter is controlled by three states. In `CNT_IDLE` the block is disabled and the counter is held at zero. On enable the state moves from `CNT_IDLE` to `CNT_UP` and the mode is sampled. `CNT_UP` moves to `CNT_DOWN` at the top in center mode. In edge mode `CNT_UP` stays in `CNT_UP` and restarts at zero. `CNT_DOWN` moves to `CNT_UP` at zero. Every state returns to `CNT_IDLE` when enable drops.

Top module: `pwm_rep_timer`

## Requirements
- R1: After reset the phase outputs, `upd_pulse` and `irq_flag` are 0. All active and preload compares and the repetition counter are 0, so the first enabled wrap produces an update.
- R2: In edge mode with reference value P and repetition value N, update pulses come every (N+1)*(P+1) clock cycles.
- R3: In center mode with reference value P ≥ 1, a wrap occurs every P cycles, at the top and at zero. Update pulses come every (N+1)*P cycles, so N=0 gives two updates per PWM period of 2P cycles.
- R4: The repetition counter reloads itself on each update, so the programmed spacing repeats without further writes.
- R5: A preload write does not change the phase outputs until the next update pulse. At that pulse the active compares take the preload values.
- R6: `upd_pulse` is high for the cycle in which the active compares first show the new values, and `irq_flag` is set in that same cycle.
- R7: `irq_flag` stays set until `irq_clr` is high at a clock edge with no update; it then reads 0.
- R8: A phase output is high while the counter is below that phase's active compare. Over one period this gives D high cycles in edge mode (capped at P+1) and 2D-1 high cycles in center mode, for D ≥ 1. A compare of 0 gives a constantly low output.
- R9: A new repetition value written while the timer runs is first used at the next reload. The interval already in progress keeps its old length.
- R10: While `enable` is low the counter stays in `CNT_IDLE`, all phase outputs are low and no update occurs. The mode is sampled only when the counter leaves `CNT_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the counter; low holds it idle |
| center_mode | input | 1 | 1 = center counting, 0 = edge counting; sampled on leaving idle |
| wr_ref | input | 1 | Write strobe for the reference preload |
| wr_u | input | 1 | Write strobe for the U phase preload |
| wr_v | input | 1 | Write strobe for the V phase preload |
| wr_w | input | 1 | Write strobe for the W phase preload |
| wr_data | input | 12 | Preload write data |
| wr_rep | input | 1 | Write strobe for the repetition value |
| rep_data | input | 8 | Repetition value write data |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| pwm_u | output | 1 | U phase PWM |
| pwm_v | output | 1 | V phase PWM |
| pwm_w | output | 1 | W phase PWM |
| upd_pulse | output | 1 | One-cycle update pulse for debug |
| irq_flag | output | 1 | Sticky update interrupt flag |

## Verification
The wrap that triggers an update is detected in one cycle. `upd_pulse`, `irq_flag` and the new active compares all appear one clock edge later. The scoreboard therefore checks the spacing between pulses rather than their absolute cycle numbers. In center mode it skips the first interval after reset, which is shortened by the zero top at start-up. Duty counts are sampled on falling edges over one full period. These windows start just after a pulse and lie well inside a repetition interval. An `irq_clr` is checked one edge after it is applied. Repetition and preload writes are issued only after a pulse has been seen, so that the interval in progress is known.

// File: rtl/pwm_rep_pkg.sv
package pwm_rep_pkg;
    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_UP   = 2'd1,
        CNT_DOWN = 2'd2
    } cnt_state_t;

    localparam int CH_REF = 0;
    localparam int CH_U   = 1;
    localparam int CH_V   = 2;
    localparam int CH_W   = 3;
    localparam int N_CH   = 4;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_rep_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             center_mode,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             running
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_t       state, nstate;
    logic [CNT_W-1:0] ncnt;
    logic             mode_q, nmode;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= CNT_IDLE;
            cnt    <= '0;
            mode_q <= 1'b0;
        end else begin
            state  <= nstate;
            cnt    <= ncnt;
            mode_q <= nmode;
        end
    end

    // transitions and wrap detection
    always_comb begin
        nstate = state;
        ncnt   = cnt;
        nmode  = mode_q;
        wrap   = 1'b0;
        unique case (state)
            CNT_IDLE: begin
                ncnt  = '0;
                nmode = center_mode;
                if (enable) nstate = CNT_UP;
            end
            CNT_UP: begin
                if (cnt >= top) begin
                    wrap = 1'b1;
                    if (mode_q) begin
                        nstate = CNT_DOWN;
                        ncnt   = (top == '0) ? '0 : top - ONE;
                    end else begin
                        ncnt = '0;
                    end
                end else begin
                    ncnt = cnt + ONE;
                end
            end
            CNT_DOWN: begin
                if (cnt == '0) begin
                    wrap   = 1'b1;
                    nstate = CNT_UP;
                    ncnt   = (top == '0) ? '0 : ONE;
                end else begin
                    ncnt = cnt - ONE;
                end
            end
            default: nstate = CNT_IDLE;
        endcase
        if (!enable) begin
            nstate = CNT_IDLE;
            ncnt   = '0;
            wrap   = 1'b0;
        end
    end

    // outputs
    always_comb running = (state != CNT_IDLE);
endmodule

// File: rtl/rep_gate.sv
module rep_gate #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             wr_rep,
    input  logic [REP_W-1:0] rep_data,
    output logic             update
);
    logic [REP_W-1:0] rep_reg, rep_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_reg <= '0;
            rep_cnt <= '0;
        end else begin
            if (wr_rep) rep_reg <= rep_data;
            if (wrap) rep_cnt <= (rep_cnt == '0) ? rep_reg : rep_cnt - REP_W'(1);
        end
    end

    always_comb update = wrap && (rep_cnt == '0);
endmodule

// File: rtl/compare_bank.sv
module compare_bank #(
    parameter int CNT_W = 12,
    parameter int N_CH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CH-1:0]            wr_en,
    input  logic [CNT_W-1:0]           wr_data,
    input  logic                       update,
    output logic [N_CH-1:0][CNT_W-1:0] act
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [CNT_W-1:0] pre;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pre    <= '0;
                act[i] <= '0;
            end else begin
                if (wr_en[i]) pre <= wr_data;
                if (update) act[i] <= pre;
            end
        end
    end
endmodule

// File: rtl/pwm_rep_timer.sv
module pwm_rep_timer
    import pwm_rep_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             center_mode,
    input  logic             wr_ref,
    input  logic             wr_u,
    input  logic             wr_v,
    input  logic             wr_w,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             wr_rep,
    input  logic [REP_W-1:0] rep_data,
    input  logic             irq_clr,
    output logic             pwm_u,
    output logic             pwm_v,
    output logic             pwm_w,
    output logic             upd_pulse,
    output logic             irq_flag
);
    localparam int N_PH = N_CH - 1;

    logic [N_CH-1:0][CNT_W-1:0] act;
    logic [CNT_W-1:0]           cnt;
    logic                       wrap, running, update;
    logic [N_PH-1:0]            pwm;

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .enable(enable), .center_mode(center_mode),
        .top(act[CH_REF]), .cnt(cnt), .wrap(wrap), .running(running)
    );

    rep_gate #(.REP_W(REP_W)) u_rep (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .wr_rep(wr_rep),
        .rep_data(rep_data), .update(update)
    );

    compare_bank #(.CNT_W(CNT_W), .N_CH(N_CH)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en({wr_w, wr_v, wr_u, wr_ref}),
        .wr_data(wr_data), .update(update), .act(act)
    );

    for (genvar p = 0; p < N_PH; p++) begin : g_ph
        assign pwm[p] = running && (cnt < act[p+1]);
    end

    assign pwm_u = pwm[CH_U-1];
    assign pwm_v = pwm[CH_V-1];
    assign pwm_w = pwm[CH_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_pulse <= 1'b0;
            irq_flag  <= 1'b0;
        end else begin
            upd_pulse <= update;
            irq_flag  <= update | (irq_flag & ~irq_clr);
        end
    end
endmodule

// File: rtl/pwm_rep_chk.sv
module pwm_rep_chk #(
    parameter int CNT_W = 12,
    parameter int N_CH  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       enable,
    input logic                       irq_clr,
    input logic                       upd_pulse,
    input logic                       irq_flag,
    input logic                       pwm_u,
    input logic                       pwm_v,
    input logic                       pwm_w,
    input logic [N_CH-1:0][CNT_W-1:0] act
);
    assert_irq_with_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> irq_flag);

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    assert_compare_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_pulse |-> $stable(act));

    assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable) |-> !(pwm_u || pwm_v || pwm_w));

    assert_idle_no_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable) |-> !upd_pulse);
endmodule

bind pwm_rep_timer pwm_rep_chk #(.CNT_W(CNT_W), .N_CH(pwm_rep_pkg::N_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .irq_clr(irq_clr),
    .upd_pulse(upd_pulse), .irq_flag(irq_flag),
    .pwm_u(pwm_u), .pwm_v(pwm_v), .pwm_w(pwm_w), .act(act)
);

// File: tb/pwm_rep_timer_tb.sv
module pwm_rep_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, center_mode = 1'b0;
    logic        wr_ref = 1'b0, wr_u = 1'b0, wr_v = 1'b0, wr_w = 1'b0;
    logic [11:0] wr_data = '0;
    logic        wr_rep = 1'b0;
    logic [7:0]  rep_data = '0;
    logic        irq_clr = 1'b0;
    logic        pwm_u, pwm_v, pwm_w, upd_pulse, irq_flag;

    always #2.5 clk = ~clk;   // 200 MHz

    pwm_rep_timer u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .center_mode(center_mode),
        .wr_ref(wr_ref), .wr_u(wr_u), .wr_v(wr_v), .wr_w(wr_w), .wr_data(wr_data),
        .wr_rep(wr_rep), .rep_data(rep_data), .irq_clr(irq_clr),
        .pwm_u(pwm_u), .pwm_v(pwm_v), .pwm_w(pwm_w),
        .upd_pulse(upd_pulse), .irq_flag(irq_flag)
    );

    int checks = 0, errors = 0;
    int cyc = 0;
    int pulses = 0;
    int exp_q[$];
    string req_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 60000) begin
            chk(1'b0, "watchdog", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // monitor: compare pulse spacing with the scoreboard queue
    int last = 0;
    bit have_last = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            have_last = 1'b0;
        end else if (upd_pulse) begin
            pulses++;
            chk(irq_flag == 1'b1, "R6 irq with pulse", int'(irq_flag), 1);
            if (have_last && exp_q.size() > 0) begin
                int e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if (e >= 0) chk((cyc - last) == e, r, cyc - last, e);
            end
            last = cyc;
            have_last = 1'b1;
        end
    end

    // driver helpers
    task automatic push(input int e, input string r);
        exp_q.push_back(e);
        req_q.push_back(r);
    endtask

    task automatic wr_pre(input int ch, input int val);
        @(negedge clk);
        wr_data = 12'(val);
        case (ch)
            0: wr_ref = 1'b1;
            1: wr_u = 1'b1;
            2: wr_v = 1'b1;
            default: wr_w = 1'b1;
        endcase
        @(negedge clk);
        {wr_ref, wr_u, wr_v, wr_w} = '0;
    endtask

    task automatic wr_rep_val(input int val);
        @(negedge clk);
        rep_data = 8'(val);
        wr_rep = 1'b1;
        @(negedge clk);
        wr_rep = 1'b0;
    endtask

    task automatic wait_pulse();
        @(posedge clk);
        @(negedge clk);
        while (!upd_pulse) @(negedge clk);
    endtask

    task automatic wait_drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic measure(input int n, output int cu, output int cv, output int cw);
        cu = 0; cv = 0; cw = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cu += int'(pwm_u); cv += int'(pwm_v); cw += int'(pwm_w);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int cu, cv, cw, pc;
        do_reset();
        chk(!pwm_u && !pwm_v && !pwm_w, "R1 phases low", int'(pwm_u | pwm_v | pwm_w), 0);
        chk(!upd_pulse, "R1 pulse low", int'(upd_pulse), 0);
        chk(!irq_flag, "R1 irq low", int'(irq_flag), 0);

        // ---- edge mode: P=9, N=2 ----
        wr_pre(0, 9); wr_pre(1, 4); wr_pre(2, 0); wr_pre(3, 10);
        wr_rep_val(2);
        center_mode = 1'b0;
        push(30, "R2 edge interval"); push(30, "R4 auto reload"); push(30, "R4 auto reload");
        enable = 1'b1;
        wait_drain();
        measure(10, cu, cv, cw);
        chk(cu == 4, "R8 edge duty U", cu, 4);
        chk(cv == 0, "R8 zero compare V", cv, 0);
        chk(cw == 10, "R8 saturated W", cw, 10);

        // R5: preload held until update
        wait_pulse();
        wr_pre(1, 7);
        measure(10, cu, cv, cw);
        chk(cu == 4, "R5 old duty before update", cu, 4);
        wait_pulse();
        measure(10, cu, cv, cw);
        chk(cu == 7, "R5 new duty after update", cu, 7);

        // R9: repetition change used at the next reload
        wait_pulse();
        @(posedge clk);
        push(30, "R9 current interval kept"); push(10, "R9 new interval"); push(10, "R9 new interval");
        wr_rep_val(0);
        wait_drain();

        // R7: sticky flag and clear
        @(negedge clk);
        chk(irq_flag, "R7 flag held", int'(irq_flag), 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(!irq_flag, "R7 flag cleared", int'(irq_flag), 0);
        wait_pulse();
        chk(irq_flag, "R7 flag set again", int'(irq_flag), 1);

        // R10: disable
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        chk(!pwm_u && !pwm_v && !pwm_w, "R10 phases low when idle", int'(pwm_u | pwm_v | pwm_w), 0);
        pc = pulses;
        center_mode = 1'b1;   // not sampled while disabled
        repeat (50) @(negedge clk);
        chk(pulses == pc, "R10 no update when idle", pulses - pc, 0);

        // ---- center mode: P=8, N=1 ----
        do_reset();
        chk(!irq_flag && !upd_pulse, "R1 cleared after reset", int'(irq_flag | upd_pulse), 0);
        wr_pre(0, 8); wr_pre(1, 3); wr_pre(2, 1); wr_pre(3, 0);
        wr_rep_val(1);
        center_mode = 1'b1;
        push(-1, "startup"); push(16, "R3 center interval"); push(16, "R4 auto reload"); push(16, "R4 auto reload");
        enable = 1'b1;
        wait_drain();
        measure(16, cu, cv, cw);
        chk(cu == 5, "R8 center duty U", cu, 5);
        chk(cv == 1, "R8 center duty V", cv, 1);
        chk(cw == 0, "R8 center zero W", cw, 0);

        wait_pulse();
        @(posedge clk);
        push(16, "R9 center current interval"); push(8, "R3 two updates per period"); push(8, "R3 two updates per period");
        wr_rep_val(0);
        wait_drain();

        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule